// File: doc/BRIEF.md
# Serial Configuration Register Port with Status Readback

This block is the slave end of a four-wire serial link from a host microcontroller. The host uses it to program a bank of sixteen 4-bit configuration registers and to read one status bit back from the drive electronics. The wires are a select line, a serial clock, a data line and a strobe. The data line is split into an input, an output and an output enable, so that a pad or a tristate buffer can be placed at the chip boundary. All four wires are resynchronised into the local clock domain. Edges are then found by comparing each synchronised level with its value one cycle earlier.

To write, the host holds select high and clocks in eight bits, most significant first: a register number nibble, then a data nibble. A rising strobe then commits the data. While the serial clock stays high, further strobe pulses commit the same byte again.

To read status, the host raises select and then raises the strobe without clocking any bits. Register 2 chooses which status signal is placed on the data line. The choices include a combined shock flag and a sticky copy of that flag.

Top module: `cfg_serial_if`

## Requirements
- R1: After reset, all sixteen registers read zero on `cfg_o` (register n occupies bits 4n+3..4n), and `sdat_oe` is low.
- R2: With select high, eight rising serial clock edges shift in bits MSB first: register number in bits 7..4, then data in bits 3..0. A rising strobe then writes the data into that register.
- R3: Each further rising strobe, with no serial clock rise in between, writes the same data into the same register again.
- R4: A rising strobe that arrives after fewer than eight bits of the current frame have been shifted in writes nothing.
- R5: A ninth rising serial clock edge starts a new frame. A strobe that follows it before the frame is complete again writes nothing.
- R6: When select is high, the strobe is high and no bits have been shifted since select rose, `sdat_oe` is high and `sdat_o` carries the status selected by register 2. The codes are: 0 subcode-ready (active low), 1 motor at or above 75%, 2 motor at or above 50%, 3 motor stopped, 4 PLL lock, 5 aux pin 0, 6 aux pin 1, 7 motor saturation, 8 FIFO overflow, 9 shock, 10 latched shock. Codes 11 to 15 read 0.
- R7: Code 3 reports `mot_stop12` when bit 0 of register 14 is 0, and reports `mot_stop6` when that bit is 1.
- R8: The shock flag is the OR of `mot_ge50`, `pll_lock`, `mot_sat`, `fifo_ovf`, `servo_irq` and `off_track`.
- R9: Once shock has been seen, the latched shock flag stays set. Every write to register 2, including a repeat write, clears it. If shock is present in the same cycle as the clear, the flag stays set.
- R10: While select is low, serial clock edges and strobe edges change no register, and `sdat_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Access select from the host, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Serial data from the host |
| sdat_o | output | 1 | Status bit driven towards the host |
| sdat_oe | output | 1 | Enable for the data line driver |
| stb_i | input | 1 | Commit / read strobe |
| subq_rdy_n | input | 1 | Subcode ready, active low |
| mot_ge75 | input | 1 | Motor at or above 75% of nominal speed |
| mot_ge50 | input | 1 | Motor at or above 50% of nominal speed |
| mot_stop12 | input | 1 | Motor at or below 12% of nominal speed |
| mot_stop6 | input | 1 | Motor at or below 6% of nominal speed |
| pll_lock | input | 1 | PLL lock indication |
| aux_pin0 | input | 1 | Pass-through status pin 0 |
| aux_pin1 | input | 1 | Pass-through status pin 1 |
| mot_sat | input | 1 | Motor output stage saturated |
| fifo_ovf | input | 1 | FIFO overflow |
| servo_irq | input | 1 | Servo interrupt condition |
| off_track | input | 1 | Off-track detection |
| cfg_o | output | 64 | All sixteen register nibbles, register n at bits 4n+3..4n |

## Verification
The bench goes after the frame-count boundaries: a strobe after five bits, and a strobe after a ninth clock. A design that commits on any strobe would corrupt the target register in both cases. A design that saturates its bit counter at eight would take the ninth clock as a shifted-in bit and then write wrong data. Repeat strobes are checked by their side effect: the extra strobe must clear the shock latch a second time. A design that commits only once would leave the latch set. The bench also checks the latch against a clearing write, and the threshold switch against a motor-stopped reading. A wrong status decode shows up as the wrong bit on the data line.

// File: rtl/cfgif_pkg.sv
package cfgif_pkg;
  // status selector codes held in the selector register
  localparam int ST_SUBQ    = 0;
  localparam int ST_MOT75   = 1;
  localparam int ST_MOT50   = 2;
  localparam int ST_MSTOP   = 3;
  localparam int ST_PLL     = 4;
  localparam int ST_AUX0    = 5;
  localparam int ST_AUX1    = 6;
  localparam int ST_MSAT    = 7;
  localparam int ST_FIFO    = 8;
  localparam int ST_SHOCK   = 9;
  localparam int ST_SHOCK_L = 10;

  // register numbers with a side role
  localparam int REG_STSEL  = 2;
  localparam int REG_MODE   = 14;

  typedef struct packed {
    logic subq_n;
    logic ge75;
    logic ge50;
    logic stop12;
    logic stop6;
    logic pll;
    logic aux0;
    logic aux1;
    logic sat;
    logic fifo;
    logic irq;
    logic otd;
  } stat_in_t;

  function automatic logic shock_of(stat_in_t s);
    return s.ge50 | s.pll | s.sat | s.fifo | s.irq | s.otd;
  endfunction

  function automatic logic stop_of(stat_in_t s, logic fine);
    return fine ? s.stop6 : s.stop12;
  endfunction
endpackage

// File: rtl/cfgif_shifter.sv
module cfgif_shifter #(
  parameter int AW   = 4,
  parameter int DW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          sclk_i,
  input  logic          sdat_i,
  input  logic          stb_i,
  output logic          sel_lvl,
  output logic          stb_lvl,
  output logic          frame_idle,
  output logic          frame_full,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int FRAME = AW + DW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int NL    = 4;

  logic [SYNC-1:0][NL-1:0] pipe;
  logic [NL-1:0]           lvl, prev;
  logic                    sclk_rise, stb_rise, sdat_lvl;
  logic [FRAME-1:0]        shreg;
  logic [CW-1:0]           cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= {stb_i, sdat_i, sclk_i, sel_i};
      for (int k = 1; k < SYNC; k++) pipe[k] <= pipe[k-1];
      prev <= lvl;
    end
  end

  assign lvl       = pipe[SYNC-1];
  assign sel_lvl   = lvl[0];
  assign sdat_lvl  = lvl[2];
  assign stb_lvl   = lvl[3];
  assign sclk_rise = lvl[1] & ~prev[1];
  assign stb_rise  = lvl[3] & ~prev[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!sel_lvl) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME-2:0], sdat_lvl};
      cnt   <= (cnt == CW'(FRAME)) ? CW'(1) : cnt + CW'(1);
    end
  end

  assign frame_idle = (cnt == '0);
  assign frame_full = (cnt == CW'(FRAME));
  assign wr_en      = sel_lvl & stb_rise & frame_full;
  assign wr_addr    = shreg[FRAME-1:DW];
  assign wr_data    = shreg[DW-1:0];
endmodule

// File: rtl/cfgif_regfile.sv
module cfgif_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 4,
  parameter int AW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (wr_en && wr_addr == AW'(i))      q <= wr_data;
    end
    assign regs_flat[i*DW +: DW] = q;
  end
endmodule

// File: rtl/cfgif_status.sv
module cfgif_status
  import cfgif_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stat_in_t      stat,
  input  logic [DW-1:0] st_sel,
  input  logic          stop_fine,
  input  logic          shock_clr,
  output logic          shock_now,
  output logic          shock_lat,
  output logic          st_bit
);
  localparam int NC = 2 ** DW;

  logic [NC-1:0] cand;

  assign shock_now = shock_of(stat);

  always_comb begin
    cand             = '0;
    cand[ST_SUBQ]    = stat.subq_n;
    cand[ST_MOT75]   = stat.ge75;
    cand[ST_MOT50]   = stat.ge50;
    cand[ST_MSTOP]   = stop_of(stat, stop_fine);
    cand[ST_PLL]     = stat.pll;
    cand[ST_AUX0]    = stat.aux0;
    cand[ST_AUX1]    = stat.aux1;
    cand[ST_MSAT]    = stat.sat;
    cand[ST_FIFO]    = stat.fifo;
    cand[ST_SHOCK]   = shock_now;
    cand[ST_SHOCK_L] = shock_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shock_lat <= 1'b0;
      st_bit    <= 1'b0;
    end else begin
      if (shock_now)      shock_lat <= 1'b1;
      else if (shock_clr) shock_lat <= 1'b0;
      st_bit <= cand[st_sel];
    end
  end
endmodule

// File: rtl/cfg_serial_if.sv
module cfg_serial_if
  import cfgif_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 4,
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               sclk_i,
  input  logic               sdat_i,
  output logic               sdat_o,
  output logic               sdat_oe,
  input  logic               stb_i,
  input  logic               subq_rdy_n,
  input  logic               mot_ge75,
  input  logic               mot_ge50,
  input  logic               mot_stop12,
  input  logic               mot_stop6,
  input  logic               pll_lock,
  input  logic               aux_pin0,
  input  logic               aux_pin1,
  input  logic               mot_sat,
  input  logic               fifo_ovf,
  input  logic               servo_irq,
  input  logic               off_track,
  output logic [NREG*DW-1:0] cfg_o
);
  localparam int AW = $clog2(NREG);

  logic          sel_lvl, stb_lvl, frame_idle, frame_full;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          shock_clr, shock_now, shock_lat;
  stat_in_t      stat;

  cfgif_shifter #(.AW(AW), .DW(DW), .SYNC(SYNC)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i),
    .sdat_i(sdat_i), .stb_i(stb_i), .sel_lvl(sel_lvl), .stb_lvl(stb_lvl),
    .frame_idle(frame_idle), .frame_full(frame_full), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cfgif_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_flat(cfg_o)
  );

  assign stat = '{subq_n: subq_rdy_n, ge75: mot_ge75, ge50: mot_ge50,
                  stop12: mot_stop12, stop6: mot_stop6, pll: pll_lock,
                  aux0: aux_pin0, aux1: aux_pin1, sat: mot_sat,
                  fifo: fifo_ovf, irq: servo_irq, otd: off_track};

  assign shock_clr = wr_en && (wr_addr == AW'(REG_STSEL));

  cfgif_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .stat(stat),
    .st_sel(cfg_o[REG_STSEL*DW +: DW]), .stop_fine(cfg_o[REG_MODE*DW]),
    .shock_clr(shock_clr), .shock_now(shock_now), .shock_lat(shock_lat),
    .st_bit(sdat_o)
  );

  assign sdat_oe = sel_lvl & stb_lvl & frame_idle;
endmodule

// File: rtl/cfgif_checker.sv
module cfgif_checker #(
  parameter int NREG = 16,
  parameter int DW   = 4,
  parameter int AW   = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic               frame_full,
  input logic               frame_idle,
  input logic               sel_lvl,
  input logic               sdat_oe,
  input logic               shock_now,
  input logic               shock_clr,
  input logic               shock_lat,
  input logic [NREG*DW-1:0] cfg_o
);
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_o[$past(wr_addr)*DW +: DW] == $past(wr_data)); // R2
  AST_COMMIT_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> frame_full); // R4
  AST_OE_IDLE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> (frame_idle && sel_lvl)); // R6
  AST_SHOCK_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    shock_now |=> shock_lat); // R9
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (shock_lat && !shock_clr) |=> shock_lat); // R9
  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (shock_clr && !shock_now) |=> !shock_lat); // R9
endmodule

bind cfg_serial_if cfgif_checker #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .frame_full(frame_full), .frame_idle(frame_idle),
  .sel_lvl(sel_lvl), .sdat_oe(sdat_oe), .shock_now(shock_now),
  .shock_clr(shock_clr), .shock_lat(shock_lat), .cfg_o(cfg_o)
);

// File: tb/tb_cfg_serial_if.sv
module tb_cfg_serial_if;
  localparam int HW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 1'b0, sclk_i = 1'b1, sdat_i = 1'b0, stb_i = 1'b0;
  logic subq_rdy_n = 1'b1, mot_ge75 = 1'b0, mot_ge50 = 1'b0;
  logic mot_stop12 = 1'b0, mot_stop6 = 1'b0, pll_lock = 1'b0;
  logic aux_pin0 = 1'b0, aux_pin1 = 1'b0, mot_sat = 1'b0, fifo_ovf = 1'b0;
  logic servo_irq = 1'b0, off_track = 1'b0;
  logic sdat_o, sdat_oe;
  logic [63:0] cfg_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [3:0] model [16];

  always #10 clk = ~clk;

  cfg_serial_if dut (.*);

  // address nibble then data nibble per entry
  localparam logic [7:0] WR_VEC [8] = '{8'h0F, 8'h1A, 8'h35, 8'h46,
                                         8'h7C, 8'h93, 8'hB8, 8'hF1};

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdat_i = b[i]; sclk_i = 1'b0; waitc(HW);
      sclk_i = 1'b1; waitc(HW);
    end
  endtask

  task automatic pulse_stb();
    stb_i = 1'b1; waitc(HW); stb_i = 1'b0; waitc(HW);
  endtask

  task automatic write_reg(logic [3:0] a, logic [3:0] d);
    sel_i = 1'b1; waitc(HW);
    send_bits({a, d}, 8);
    pulse_stb();
    sel_i = 1'b0; waitc(HW);
    model[a] = d;
  endtask

  task automatic read_status(string req, logic exp);
    sel_i = 1'b1; waitc(HW);
    stb_i = 1'b1; waitc(HW);
    check(req, {31'd0, sdat_oe}, 32'd1);
    check(req, {31'd0, sdat_o}, {31'd0, exp});
    stb_i = 1'b0; waitc(HW);
    sel_i = 1'b0; waitc(HW);
  endtask

  task automatic check_regs(string req);
    for (int r = 0; r < 16; r++) check(req, cfg_o[r*4 +: 4], model[r]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = 4'h0;
    waitc(4);
    // R1: reset state
    check("R1 cfg", cfg_o[31:0], 32'd0);
    check("R1 cfg_hi", cfg_o[63:32], 32'd0);
    check("R1 oe", {31'd0, sdat_oe}, 32'd0);
    rst_n = 1'b1; waitc(4);

    // R2: table of writes
    for (int v = 0; v < 8; v++) begin
      write_reg(WR_VEC[v][7:4], WR_VEC[v][3:0]);
      check("R2", cfg_o[WR_VEC[v][7:4]*4 +: 4], WR_VEC[v][3:0]);
    end
    write_reg(4'h1, 4'h5);
    check_regs("R2 all");

    // R4: strobe after five bits
    sel_i = 1'b1; waitc(HW);
    send_bits(8'h1E, 5);
    pulse_stb();
    sel_i = 1'b0; waitc(HW);
    check("R4", cfg_o[1*4 +: 4], 4'h5);

    // R5: ninth clock restarts frame
    write_reg(4'h7, 4'h3);
    sel_i = 1'b1; waitc(HW);
    send_bits(8'h7C, 8);
    send_bits(8'h80, 1);
    pulse_stb();
    sel_i = 1'b0; waitc(HW);
    check("R5", cfg_o[7*4 +: 4], 4'h3);

    // R10: select low ignores everything
    send_bits(8'h79, 8);
    pulse_stb();
    stb_i = 1'b1; waitc(HW);
    check("R10 oe", {31'd0, sdat_oe}, 32'd0);
    stb_i = 1'b0; waitc(HW);
    check("R10 reg", cfg_o[7*4 +: 4], 4'h3);

    // R6: status codes, one input high at a time
    write_reg(4'h2, 4'd0);
    subq_rdy_n = 1'b0; waitc(HW);
    read_status("R6 subq", 1'b0);
    subq_rdy_n = 1'b1;
    write_reg(4'h2, 4'd1); mot_ge75 = 1'b1; waitc(HW);
    read_status("R6 ge75", 1'b1); mot_ge75 = 1'b0;
    write_reg(4'h2, 4'd4); pll_lock = 1'b1; waitc(HW);
    read_status("R6 pll", 1'b1); pll_lock = 1'b0;
    write_reg(4'h2, 4'd5); aux_pin0 = 1'b1; waitc(HW);
    read_status("R6 aux0", 1'b1); aux_pin0 = 1'b0;
    write_reg(4'h2, 4'd6); aux_pin1 = 1'b1; waitc(HW);
    read_status("R6 aux1", 1'b1); aux_pin1 = 1'b0;
    write_reg(4'h2, 4'd7); mot_sat = 1'b1; waitc(HW);
    read_status("R6 sat", 1'b1); mot_sat = 1'b0;
    write_reg(4'h2, 4'd12); aux_pin0 = 1'b1; mot_ge75 = 1'b1; waitc(HW);
    read_status("R6 unused", 1'b0); aux_pin0 = 1'b0; mot_ge75 = 1'b0;

    // R7: motor stop threshold select
    write_reg(4'h2, 4'd3); mot_stop12 = 1'b1; mot_stop6 = 1'b0;
    write_reg(4'hE, 4'd0); waitc(HW);
    read_status("R7 coarse", 1'b1);
    write_reg(4'hE, 4'd1); waitc(HW);
    read_status("R7 fine", 1'b0);
    mot_stop12 = 1'b0; mot_stop6 = 1'b1; waitc(HW);
    read_status("R7 fine6", 1'b1);
    mot_stop6 = 1'b0;

    // R8: live shock from servo interrupt and off-track
    write_reg(4'h2, 4'd9); servo_irq = 1'b1; waitc(HW);
    read_status("R8 irq", 1'b1); servo_irq = 1'b0; waitc(HW);
    read_status("R8 quiet", 1'b0);
    off_track = 1'b1; waitc(HW);
    read_status("R8 otd", 1'b1); off_track = 1'b0;

    // R9: latched shock sticky and clearing
    write_reg(4'h2, 4'd10); waitc(HW);
    read_status("R9 cleared", 1'b0);
    fifo_ovf = 1'b1; waitc(HW); fifo_ovf = 1'b0; waitc(HW);
    read_status("R9 sticky", 1'b1);
    read_status("R9 sticky2", 1'b1);
    write_reg(4'h2, 4'd10); waitc(HW);
    read_status("R9 clr", 1'b0);

    // R3: repeat strobe re-commits reg 2 and clears latch again
    sel_i = 1'b1; waitc(HW);
    send_bits({4'h2, 4'd10}, 8);
    pulse_stb();
    mot_ge50 = 1'b1; waitc(HW); mot_ge50 = 1'b0; waitc(HW);
    pulse_stb();
    sel_i = 1'b0; waitc(HW);
    check("R3 data", cfg_o[2*4 +: 4], 4'd10);
    read_status("R3 recommit", 1'b0);

    check_regs("R2 final");
    finish_run();
  end
endmodule